// File: doc/BRIEF.md
# Ganged Dual-Lane Integer Datapath

This block is the integer execution stage of a core that has two 64-bit lanes. Each lane has its own adder, logic unit and shifter. Each operation carries a mode bit. When the bit is clear, the lanes work as two independent 64-bit units on the low and high halves of the operands. When it is set, the lanes act as one 128-bit datapath: the carry passes from the low lane to the high lane within the cycle, and wide shifts go through a single shared 128-bit shifter. The mode is chosen again for every operation, so no global switch is needed.

Lane 0 keeps a stored shift amount. A dedicated load operation writes it, and funnel shifts use it to take a window out of the joined operands. Lane 1 has a leading-zero counter. Every result is registered and leaves the block one clock after the operation is presented, together with a valid flag.

Top module: `gang_alu`

## Requirements
- R1: A result appears on `result` with `out_valid` high one clock edge after the edge at which `in_valid` was high. After an edge with `in_valid` low, `out_valid` is low and `result` keeps its previous value.
- R2: While `rst_n` is low, `out_valid`, `result` and the stored shift amount are all zero.
- R3: Opcode 0 is add and opcode 1 is subtract (a minus b). With `wide`=0, each 64-bit half is computed alone and no carry or borrow crosses bit 63/64. With `wide`=1, the 128-bit operands are treated as one number.
- R4: Opcodes 2, 3 and 4 give the bitwise AND, OR and XOR of `a` and `b` over all 128 bits, in both modes.
- R5: Opcodes 5, 6 and 7 are the shift-left, logical shift-right and arithmetic shift-right of `a`. With `wide`=0, each half shifts on its own by bits [5:0] of the matching half of `b`, and no bit crosses between the halves.
- R6: With `wide`=1, opcodes 5 to 7 shift the full 128-bit `a` by `b[6:0]`, and bits move between the halves.
- R7: Opcode 9 loads `b[6:0]` into the stored shift amount and returns a zero result. The stored amount keeps its value through all other operations and through idle cycles. An opcode 9 presented with `in_valid` low does not change it.
- R8: Opcode 8 is the funnel shift, using the stored amount. With `wide`=1, the result is the low 128 bits of {a,b} shifted right by the amount. With `wide`=0, each half gives the low 64 bits of {a_half,b_half} shifted right by the low 6 bits of the amount.
- R9: Opcode 10 returns the number of leading zeros of `a[127:64]` in `result[6:0]`, with all other bits zero. An all-zero input gives 64. The result does not depend on `wide` or on `a[63:0]`.
- R10: Opcodes 11 to 15 return a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = one 128-bit operation, 0 = two 64-bit operations |
| a | input | 128 | First operand, lane 1 in [127:64] |
| b | input | 128 | Second operand / shift amounts |
| out_valid | output | 1 | Registered result valid |
| result | output | 128 | Registered result |

## Verification
The bench targets the lane boundary in every operation class. It uses an add whose low half overflows and a subtract whose low half borrows, and both should be seen in the high half only in wide mode. A design that always chains the carry, or never chains it, gives a high half that is off by one. It shifts values across bit 63 in both modes, which catches a shared shifter that is used in narrow mode or a lane shifter that leaks bits into its neighbour. It checks that the stored funnel amount survives idle cycles, an ignored load and reset. It also checks that the leading-zero count of zero is 64 and not 63 or 0, and that undefined opcodes give zero.

// File: rtl/gang_alu_pkg.sv
package gang_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_FUNL = 4'd8,
        OP_LDSA = 4'd9,
        OP_LZC  = 4'd10
    } op_e;
endpackage

// File: rtl/lane_alu.sv
module lane_alu
    import gang_alu_pkg::*;
#(
    parameter int W = 64,
    localparam int SHW = $clog2(W)
) (
    input  op_e            op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    input  logic [SHW-1:0] fsa,
    output logic [W-1:0]   res,
    output logic           cout
);
    logic [W-1:0]   b_eff;
    logic [W:0]     sum;
    logic [2*W-1:0] joined;
    logic [SHW-1:0] sh;

    always_comb begin
        b_eff  = (op == OP_SUB) ? ~b : b;
        sum    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        cout   = sum[W];
        sh     = b[SHW-1:0];
        joined = {a, b} >> fsa;
        unique case (op)
            OP_ADD, OP_SUB: res = sum[W-1:0];
            OP_AND:         res = a & b;
            OP_OR:          res = a | b;
            OP_XOR:         res = a ^ b;
            OP_SLL:         res = a << sh;
            OP_SRL:         res = a >> sh;
            OP_SRA:         res = W'($signed(a) >>> sh);
            OP_FUNL:        res = joined[W-1:0];
            default:        res = '0;
        endcase
    end
endmodule

// File: rtl/wide_shifter.sv
module wide_shifter
    import gang_alu_pkg::*;
#(
    parameter int W = 128,
    localparam int SHW = $clog2(W)
) (
    input  op_e            op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   res
);
    logic [2*W-1:0] joined;

    always_comb begin
        joined = {a, b} >> amt;
        unique case (op)
            OP_SLL:  res = a << amt;
            OP_SRL:  res = a >> amt;
            OP_SRA:  res = W'($signed(a) >>> amt);
            OP_FUNL: res = joined[W-1:0];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/lzc_unit.sv
module lzc_unit #(
    parameter int W = 64,
    localparam int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] count
);
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/gang_alu.sv
module gang_alu
    import gang_alu_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int LANES  = 2,
    localparam int FULL_W = LANE_W * LANES,
    localparam int LSHW   = $clog2(LANE_W),
    localparam int SAW    = $clog2(FULL_W),
    localparam int CW     = $clog2(LANE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              wide,
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    output logic              out_valid,
    output logic [FULL_W-1:0] result
);
    typedef struct packed {
        logic              valid;
        logic [FULL_W-1:0] res;
        logic [SAW-1:0]    sa;
    } state_t;

    state_t state_d, state_q;
    op_e    op_c;

    logic [LANE_W-1:0] lane_res  [LANES];
    logic              lane_cout [LANES];
    logic              lane_cin  [LANES];
    logic [FULL_W-1:0] wsh_res;
    logic [SAW-1:0]    wsh_amt;
    logic [CW-1:0]     lz_count;
    logic [FULL_W-1:0] lanes_cat;

    assign op_c = op_e'(op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_cin[g] = (op_c == OP_SUB);
        end else begin : g_rest
            assign lane_cin[g] = wide ? lane_cout[g-1] : (op_c == OP_SUB);
        end
        lane_alu #(.W(LANE_W)) u_lane (
            .op   (op_c),
            .a    (a[g*LANE_W +: LANE_W]),
            .b    (b[g*LANE_W +: LANE_W]),
            .cin  (lane_cin[g]),
            .fsa  (state_q.sa[LSHW-1:0]),
            .res  (lane_res[g]),
            .cout (lane_cout[g])
        );
        assign lanes_cat[g*LANE_W +: LANE_W] = lane_res[g];
    end

    assign wsh_amt = (op_c == OP_FUNL) ? state_q.sa : b[SAW-1:0];

    wide_shifter #(.W(FULL_W)) u_wsh (
        .op  (op_c),
        .a   (a),
        .b   (b),
        .amt (wsh_amt),
        .res (wsh_res)
    );

    lzc_unit #(.W(LANE_W)) u_lzc (
        .val   (a[FULL_W-1 -: LANE_W]),
        .count (lz_count)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            unique case (op_c)
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:
                    state_d.res = lanes_cat;
                OP_SLL, OP_SRL, OP_SRA, OP_FUNL:
                    state_d.res = wide ? wsh_res : lanes_cat;
                OP_LDSA: begin
                    state_d.res = '0;
                    state_d.sa  = b[SAW-1:0];
                end
                OP_LZC:
                    state_d.res = FULL_W'(lz_count);
                default:
                    state_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.res;
endmodule

// File: rtl/gang_alu_chk.sv
module gang_alu_chk #(
    parameter int FULL_W = 128,
    parameter int SAW    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3:0]        op,
    input logic              wide,
    input logic [FULL_W-1:0] a,
    input logic [FULL_W-1:0] b,
    input logic              out_valid,
    input logic [FULL_W-1:0] result,
    input logic [SAW-1:0]    sa
);
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R1
    AST_AND_BITWISE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 4'd2) |=> result == $past(a & b)); // R4
    AST_LDSA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 4'd9) |=> result == '0); // R7
    AST_SA_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && op == 4'd9) |=> $stable(sa)); // R7
    AST_LZC_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 4'd10) |=> (result[FULL_W-1:SAW] == '0 && result[SAW-1:0] <= SAW'(64))); // R9
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op > 4'd10) |=> result == '0); // R10
    AST_WIDE_UNUSED: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 4'd10) |=> (result[SAW-1:0] == 7'd64) == ($past(a[FULL_W-1 -: 64]) == '0)); // R9
endmodule

bind gang_alu gang_alu_chk #(.FULL_W(FULL_W), .SAW(SAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .wide      (wide),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result),
    .sa        (state_q.sa)
);

// File: tb/tb_gang_alu.sv
module tb_gang_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic         wide = 1'b0;
    logic [127:0] a = '0;
    logic [127:0] b = '0;
    logic         out_valid;
    logic [127:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [3:0]   op;
        logic         wide;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, {64'd5, ONES}, {64'd3, 64'd1}, {64'd8, 64'd0}},     // R3 narrow add, no carry cross
        '{4'd0, 1'b1, {64'd5, ONES}, {64'd3, 64'd1}, {64'd9, 64'd0}},     // R3 wide add, carry crosses
        '{4'd1, 1'b0, {64'd0, 64'd0}, {64'd1, 64'd1}, {ONES, ONES}},      // R3 narrow sub
        '{4'd1, 1'b1, {64'd1, 64'd0}, {64'd0, 64'd1}, {64'd0, ONES}},     // R3 wide sub, borrow crosses
        '{4'd2, 1'b0, {64'hFF00, 64'h0F0F}, {64'h0FF0, 64'hFFFF}, {64'h0F00, 64'h0F0F}}, // R4
        '{4'd4, 1'b1, {64'h1, 64'h2}, {64'h3, 64'h2}, {64'h2, 64'h0}},    // R4
        '{4'd3, 1'b0, {64'h1, 64'h0}, {64'h2, 64'h0}, {64'h3, 64'h0}},    // R4
        '{4'd5, 1'b0, {64'h1, MSB}, {64'd4, 64'd1}, {64'h10, 64'h0}},     // R5 no crossing
        '{4'd7, 1'b0, {MSB, MSB}, {64'd63, 64'd0}, {ONES, MSB}},          // R5 per-lane amount
        '{4'd5, 1'b1, {64'h0, MSB}, {64'd0, 64'd1}, {64'h1, 64'h0}},      // R6
        '{4'd6, 1'b1, {64'h1, 64'h0}, {64'd0, 64'd64}, {64'h0, 64'h1}},   // R6
        '{4'd7, 1'b1, {MSB, 64'h0}, {64'd0, 64'd64}, {ONES, MSB}}         // R6
    };

    gang_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .wide      (wide),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .result    (result)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [3:0] o, input logic w, input logic [127:0] xa,
                          input logic [127:0] xb, input logic v);
        @(negedge clk);
        in_valid = v; op = o; wide = w; a = xa; b = xb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset valid", {127'd0, out_valid}, 128'd0);
        chk("R2 reset result", result, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].wide, VECS[i].a, VECS[i].b, 1'b1);
            chk("R1 valid", {127'd0, out_valid}, 128'd1);
            chk($sformatf("R3-6 vector %0d", i), result, VECS[i].exp);
        end

        // R1 idle hold
        run_op(4'd0, 1'b0, 128'd7, 128'd7, 1'b0);
        chk("R1 idle valid", {127'd0, out_valid}, 128'd0);
        chk("R1 idle hold", result, {ONES, MSB});

        // R7 load amount 68, zero result
        run_op(4'd9, 1'b0, 128'd0, 128'd68, 1'b1);
        chk("R7 load result zero", result, 128'd0);
        // R8 narrow funnel with low 6 bits = 4
        run_op(4'd8, 1'b0, {64'h0, 64'hA}, {64'h30, 64'h0}, 1'b1);
        chk("R8 narrow funnel", result, {64'h3, 64'hA000_0000_0000_0000});
        // R8 wide funnel by 68
        run_op(4'd8, 1'b1, 128'h1, {64'h50, 64'h0}, 1'b1);
        chk("R8 wide funnel", result, {64'h0, 64'h1000_0000_0000_0005});
        // R7 ignored load with in_valid low, amount must persist
        run_op(4'd9, 1'b0, 128'd0, 128'd0, 1'b0);
        run_op(4'd0, 1'b0, 128'd1, 128'd1, 1'b1);
        run_op(4'd8, 1'b1, 128'h1, {64'h50, 64'h0}, 1'b1);
        chk("R7 amount kept", result, {64'h0, 64'h1000_0000_0000_0005});

        // R9 leading zeros
        run_op(4'd10, 1'b1, {64'h0, ONES}, 128'd0, 1'b1);
        chk("R9 lzc zero input", result, 128'd64);
        run_op(4'd10, 1'b0, {64'h1, 64'h0}, 128'd0, 1'b1);
        chk("R9 lzc one", result, 128'd63);
        run_op(4'd10, 1'b0, {MSB, ONES}, ONES, 1'b1);
        chk("R9 lzc top bit", result, 128'd0);

        // R10 undefined opcodes
        run_op(4'd3, 1'b0, 128'd5, 128'd2, 1'b1);
        run_op(4'd15, 1'b0, 128'd5, 128'd2, 1'b1);
        chk("R10 undefined op", result, 128'd0);
        run_op(4'd11, 1'b1, ~128'd0, ~128'd0, 1'b1);
        chk("R10 undefined op 11", result, 128'd0);

        // R2 reset clears stored amount
        run_op(4'd9, 1'b0, 128'd0, 128'd68, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 reset valid mid-run", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        run_op(4'd8, 1'b0, {64'h0, 64'hA}, {64'h30, 64'h77}, 1'b1);
        chk("R2 amount cleared", result, {64'h30, 64'h77});

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule